// File: doc/BRIEF.md
# I2C Bus Timing Divisor Search Engine

This block turns a source clock frequency and a wanted serial bus speed into the two counts that set the bus clock. The bus frequency comes out as the source frequency divided by twice the product of a sample count and a step count. The engine looks for the pair with the smallest product that still keeps the bus at or below the wanted speed. It returns each count minus one, ready to be packed into a timing word by the logic around it.

A job starts with a one-cycle `start` pulse while the engine is idle. The engine clamps the target, picks a step limit from the target speed, and computes the required divisor with a shared iterative divider. It then tries sample counts one after another and stops early on an exact fit. A final range check flags an error when even the slowest setting found would still run faster than the target. The result and error flag appear with a one-cycle `done` pulse. They are held until the next job finishes.

Top module: `i2c_divisor_search`

## Requirements
- R1: After reset, `done` and `err` are 0 and `sample_enc` and `step_enc` are 0.
- R2: A target above 3,400,000 Hz gives the same result as a target of exactly 3,400,000 Hz.
- R3: The step count may not exceed 8 when the clamped target is above 400,000 Hz, and may not exceed 64 otherwise. With a target above 400,000 Hz, a successful `step_enc` is at most 7.
- R4: The required divisor D is ceil((src_hz >> 1) / target), where target is the clamped target.
- R5: Sample counts 1 to 8 are tried in rising order. For each sample count s, the step count is ceil(D / s). A candidate whose step count is over the limit is skipped. A candidate becomes the new best only when s times its step count is strictly smaller than the best so far. The search stops as soon as that product equals D.
- R6: The starting best is a sample count of 8 with the step limit as the step count. It is kept when no candidate beats it.
- R7: When floor(src_hz / (2 x sample x step)) for the chosen pair is above the clamped target, `err` is 1 and both encoded fields are 0.
- R8: On success, `err` is 0, `sample_enc` is the chosen sample count minus 1 and `step_enc` is the chosen step count minus 1.
- R9: A target of 0 or a source below 2 Hz sets `err` with `done` on the first clock edge after the accepted `start`, without running the divider.
- R10: `done` is high for exactly one cycle per job. `err`, `sample_enc` and `step_enc` change only in the cycle where `done` is high.
- R11: A `start` pulse that arrives while a job is running is ignored, and the running job's result is not disturbed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request; taken only when idle |
| src_hz | input | 32 | Source clock frequency in Hz |
| target_hz | input | 32 | Wanted bus speed in Hz |
| done | output | 1 | One-cycle pulse when a result is ready |
| err | output | 1 | Wanted speed cannot be reached |
| sample_enc | output | 3 | Chosen sample count minus one |
| step_enc | output | 6 | Chosen step count minus one |

## Verification
A wrong divisor, a wrong step limit or a broken comparison in the best-pair tracker shows up as a wrong encoded pair, or as a wrong error flag, in the `done` cycle of the same job. A stuck sample counter or a lost divider handshake shows up as a missing or late `done`. The zero-target path can be checked within one cycle of `start`. Random source and target pairs are compared against a bench model of the search. Directed cases cover clamping, the fast-mode step limit, the early exit, the too-slow error and a `start` pulse during a busy job.

// File: rtl/divsrch_pkg.sv
package divsrch_pkg;
  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_OPT   = 2'd1,
    S_STEP  = 2'd2,
    S_CHECK = 2'd3
  } srch_state_t;
endpackage

// File: rtl/divsrch_divider.sv
// Restoring divider: one quotient bit per cycle, W cycles per division.
module divsrch_divider #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quot,
  output logic [W-1:0] rem
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0] rem_q, quo_q, den_q;
  logic [CW-1:0] cnt_q;
  logic [W:0]   trial;
  logic         fits;

  assign trial = {rem_q, quo_q[W-1]};
  assign fits  = trial >= {1'b0, den_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
      quo_q <= '0;
      den_q <= '0;
      cnt_q <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        rem_q <= '0;
        quo_q <= dividend;
        den_q <= divisor;
        cnt_q <= '0;
        busy  <= 1'b1;
      end else if (busy) begin
        if (fits) rem_q <= W'(trial - {1'b0, den_q});
        else      rem_q <= trial[W-1:0];
        quo_q <= {quo_q[W-2:0], fits};
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CW'(W - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign quot = quo_q;
  assign rem  = rem_q;
endmodule

// File: rtl/divsrch_best.sv
// Holds the best (sample, step) pair and judges each new candidate.
module divsrch_best #(
  parameter int W          = 32,
  parameter int SW         = 4,
  parameter int TW         = 7,
  parameter int MAX_SAMPLE = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            init,
  input  logic [TW-1:0]   lim,
  input  logic            upd,
  input  logic [SW-1:0]   cand_s,
  input  logic [W-1:0]    cand_t,
  input  logic [W+SW-1:0] cand_m,
  output logic            better,
  output logic [SW-1:0]   best_s,
  output logic [TW-1:0]   best_t,
  output logic [W+SW-1:0] best_m
);
  localparam int MW = W + SW;

  logic [TW-1:0] lim_q;
  logic          in_range;

  always_ff @(posedge clk) begin
    if (rst) lim_q <= '0;
    else if (init) lim_q <= lim;
  end

  assign in_range = cand_t <= W'(lim_q);
  assign better   = in_range && (cand_m < best_m);

  always_ff @(posedge clk) begin
    if (rst) begin
      best_s <= '0;
      best_t <= '0;
      best_m <= '0;
    end else if (init) begin
      best_s <= SW'(MAX_SAMPLE);
      best_t <= lim;
      best_m <= MW'(MAX_SAMPLE) * MW'(lim);
    end else if (upd && better) begin
      best_s <= cand_s;
      best_t <= cand_t[TW-1:0];
      best_m <= cand_m;
    end
  end
endmodule

// File: rtl/divsrch_range.sv
// Flags a pair whose bus rate would still exceed the target.
module divsrch_range #(
  parameter int W  = 32,
  parameter int SW = 4,
  parameter int TW = 7
) (
  input  logic [W-1:0]  src,
  input  logic [W-1:0]  tgt,
  input  logic [SW-1:0] s,
  input  logic [TW-1:0] t,
  output logic          too_slow
);
  localparam int DW = SW + TW + 1;
  localparam int PW = W + 1 + DW;

  logic [DW-1:0] den;
  logic [PW-1:0] limit;

  // floor(src / den) > tgt  <=>  src >= (tgt + 1) * den
  assign den      = DW'(DW'(s) * DW'(t)) << 1;
  assign limit    = (PW'(tgt) + PW'(1)) * PW'(den);
  assign too_slow = PW'(src) >= limit;
endmodule

// File: rtl/i2c_divisor_search.sv
module i2c_divisor_search
  import divsrch_pkg::*;
#(
  parameter int W          = 32,
  parameter int MAX_SAMPLE = 8,
  parameter int STEP_FAST  = 8,
  parameter int STEP_SLOW  = 64,
  parameter int HS_CEIL    = 3400000,
  parameter int FS_CEIL    = 400000,
  localparam int SENC_W    = $clog2(MAX_SAMPLE),
  localparam int TENC_W    = $clog2(STEP_SLOW)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [W-1:0]      src_hz,
  input  logic [W-1:0]      target_hz,
  output logic              done,
  output logic              err,
  output logic [SENC_W-1:0] sample_enc,
  output logic [TENC_W-1:0] step_enc
);
  localparam int SW = $clog2(MAX_SAMPLE + 1);
  localparam int TW = $clog2(STEP_SLOW + 1);
  localparam int MW = W + SW;

  srch_state_t   st_q;
  logic [W-1:0]  src_q, tgt_q, opt_q;
  logic [TW-1:0] lim_q;
  logic [SW-1:0] s_q;
  logic          busy;

  logic [W-1:0]  tgt_cl;
  logic [TW-1:0] lim_now;
  logic          bad_req, take;

  logic          div_go, div_busy, div_done;
  logic [W-1:0]  div_a, div_b, div_q, div_r, ceil_now;

  logic [MW-1:0] cand_m, best_m;
  logic          better, exact_hit, last_cand, too_slow;
  logic [SW-1:0] best_s;
  logic [TW-1:0] best_t;

  assign busy    = st_q != S_IDLE;
  assign tgt_cl  = (target_hz > W'(HS_CEIL)) ? W'(HS_CEIL) : target_hz;
  assign lim_now = (tgt_cl > W'(FS_CEIL)) ? TW'(STEP_FAST) : TW'(STEP_SLOW);
  assign bad_req = (target_hz == '0) || (src_hz < W'(2));
  assign take    = (st_q == S_IDLE) && start;

  assign ceil_now  = div_q + W'(div_r != '0);
  assign cand_m    = MW'(ceil_now) * MW'(s_q);
  assign exact_hit = better && (cand_m == MW'(opt_q));
  assign last_cand = exact_hit || (s_q == SW'(MAX_SAMPLE));

  always_comb begin
    div_go = 1'b0;
    div_a  = opt_q;
    div_b  = W'(s_q) + W'(1);
    case (st_q)
      S_IDLE: begin
        div_go = take && !bad_req;
        div_a  = src_hz >> 1;
        div_b  = tgt_cl;
      end
      S_OPT: begin
        div_go = div_done;
        div_a  = ceil_now;
        div_b  = W'(1);
      end
      S_STEP: begin
        div_go = div_done && !last_cand;
      end
      default: ;
    endcase
  end

  divsrch_divider #(.W(W)) u_div (
    .clk      (clk),
    .rst      (rst),
    .go       (div_go),
    .dividend (div_a),
    .divisor  (div_b),
    .busy     (div_busy),
    .done     (div_done),
    .quot     (div_q),
    .rem      (div_r)
  );

  divsrch_best #(.W(W), .SW(SW), .TW(TW), .MAX_SAMPLE(MAX_SAMPLE)) u_best (
    .clk    (clk),
    .rst    (rst),
    .init   (take && !bad_req),
    .lim    (lim_now),
    .upd    ((st_q == S_STEP) && div_done),
    .cand_s (s_q),
    .cand_t (ceil_now),
    .cand_m (cand_m),
    .better (better),
    .best_s (best_s),
    .best_t (best_t),
    .best_m (best_m)
  );

  divsrch_range #(.W(W), .SW(SW), .TW(TW)) u_range (
    .src      (src_q),
    .tgt      (tgt_q),
    .s        (best_s),
    .t        (best_t),
    .too_slow (too_slow)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= S_IDLE;
      src_q      <= '0;
      tgt_q      <= '0;
      opt_q      <= '0;
      lim_q      <= '0;
      s_q        <= '0;
      done       <= 1'b0;
      err        <= 1'b0;
      sample_enc <= '0;
      step_enc   <= '0;
    end else begin
      done <= 1'b0;
      case (st_q)
        S_IDLE: begin
          if (take) begin
            src_q <= src_hz;
            tgt_q <= tgt_cl;
            lim_q <= lim_now;
            if (bad_req) begin
              done       <= 1'b1;
              err        <= 1'b1;
              sample_enc <= '0;
              step_enc   <= '0;
            end else begin
              st_q <= S_OPT;
            end
          end
        end
        S_OPT: begin
          if (div_done) begin
            opt_q <= ceil_now;
            s_q   <= SW'(1);
            st_q  <= S_STEP;
          end
        end
        S_STEP: begin
          if (div_done) begin
            if (last_cand) st_q <= S_CHECK;
            else           s_q  <= s_q + 1'b1;
          end
        end
        S_CHECK: begin
          done <= 1'b1;
          err  <= too_slow;
          if (too_slow) begin
            sample_enc <= '0;
            step_enc   <= '0;
          end else begin
            sample_enc <= SENC_W'(best_s - 1'b1);
            step_enc   <= TENC_W'(best_t - 1'b1);
          end
          st_q <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/divsrch_checker.sv
module divsrch_checker #(
  parameter int W       = 32,
  parameter int FS_CEIL = 400000,
  parameter int SENC_W  = 3,
  parameter int TENC_W  = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [W-1:0]      src_hz,
  input logic [W-1:0]      target_hz,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic [SENC_W-1:0] sample_enc,
  input logic [TENC_W-1:0] step_enc,
  input logic [W-1:0]      tgt_q
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable({err, sample_enc, step_enc})); // R10

  AST_BAD_REQ_FAST: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && (target_hz == '0 || src_hz < W'(2))) |=> (done && err)); // R9

  AST_ERR_FIELDS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (done && err) |-> (sample_enc == '0 && step_enc == '0)); // R7

  AST_FAST_STEP_LIMIT: assert property (@(posedge clk) disable iff (rst)
    (done && !err && tgt_q > W'(FS_CEIL)) |-> (step_enc < TENC_W'(8))); // R3

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> (busy || done)); // R11
endmodule

bind i2c_divisor_search divsrch_checker #(
  .W(W), .FS_CEIL(FS_CEIL), .SENC_W(SENC_W), .TENC_W(TENC_W)
) i_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .src_hz     (src_hz),
  .target_hz  (target_hz),
  .busy       (busy),
  .done       (done),
  .err        (err),
  .sample_enc (sample_enc),
  .step_enc   (step_enc),
  .tgt_q      (tgt_q)
);

// File: tb/test_i2c_divisor_search.sv
module test_i2c_divisor_search;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] src_hz = '0;
  logic [31:0] target_hz = '0;
  logic        done, err;
  logic [2:0]  sample_enc;
  logic [5:0]  step_enc;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  i2c_divisor_search i_i2c_divisor_search (
    .clk(clk), .rst(rst), .start(start), .src_hz(src_hz), .target_hz(target_hz),
    .done(done), .err(err), .sample_enc(sample_enc), .step_enc(step_enc)
  );

  function automatic void model(input longint src, input longint tgt,
                                output bit e, output int se, output int te);
    longint t, lim, opt, best, st, m;
    int bs, bt;
    if (tgt == 0 || src < 2) begin e = 1; se = 0; te = 0; return; end
    t    = (tgt > 3400000) ? 3400000 : tgt;
    lim  = (t > 400000) ? 8 : 64;
    opt  = ((src >> 1) + t - 1) / t;
    best = 8 * lim; bs = 8; bt = int'(lim);
    for (int s = 1; s <= 8; s++) begin
      st = (opt + s - 1) / s;
      m  = st * s;
      if (st > lim) continue;
      if (m < best) begin
        best = m; bs = s; bt = int'(st);
        if (m == opt) break;
      end
    end
    if (src / (2 * bs * bt) > t) begin e = 1; se = 0; te = 0; end
    else begin e = 0; se = bs - 1; te = bt - 1; end
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_job(input logic [31:0] s, input logic [31:0] t, output int lat);
    @(negedge clk);
    src_hz = s; target_hz = t; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 5000) begin
      @(negedge clk);
      lat++;
    end
    if (!done) chk("R10 timeout", 0, 1);
  endtask

  task automatic job_vs_model(input string tag, input logic [31:0] s, input logic [31:0] t);
    int lat, se, te;
    bit e;
    run_job(s, t, lat);
    model(s, t, e, se, te);
    chk({tag, " err"}, err, e);
    chk({tag, " sample_enc"}, sample_enc, se);
    chk({tag, " step_enc"}, step_enc, te);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000 && !finished) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=<190000", cyc);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
      end
    end
  end

  initial begin
    int lat, se, te;
    bit e;
    logic e0;
    logic [2:0] s0;
    logic [5:0] t0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 done", done, 0);
    chk("R1 err", err, 0);
    chk("R1 sample_enc", sample_enc, 0);
    chk("R1 step_enc", step_enc, 0);

    // R4 R5 R8 standard mode
    job_vs_model("R4 std 100M/100k", 32'd100_000_000, 32'd100_000);
    chk("R8 std err", err, 0);
    job_vs_model("R5 fast 66M/400k", 32'd66_000_000, 32'd400_000);
    // R5 early exit: D = 12 exactly -> sample 1, step 12
    run_job(32'd24 * 32'd100_000, 32'd100_000, lat);
    chk("R5 exact sample_enc", sample_enc, 0);
    chk("R8 exact step_enc", step_enc, 11);
    // R3 fast-mode step limit
    job_vs_model("R3 hs 100M/1M", 32'd100_000_000, 32'd1_000_000);
    chk("R3 step_enc<=7", step_enc <= 7, 1);
    // R2 clamp equivalence
    run_job(32'd200_000_000, 32'd3_400_000, lat);
    e0 = err; s0 = sample_enc; t0 = step_enc;
    run_job(32'd200_000_000, 32'd9_000_000, lat);
    chk("R2 clamp err", err, e0);
    chk("R2 clamp sample_enc", sample_enc, s0);
    chk("R2 clamp step_enc", step_enc, t0);
    // R6 R7 too slow: no candidate fits, default pair fails range check
    job_vs_model("R7 slow 1G/1k", 32'd1_000_000_000, 32'd1_000);
    chk("R6 R7 err set", err, 1);
    // R9 zero target / tiny source
    run_job(32'd100_000_000, 32'd0, lat);
    chk("R9 zero latency", lat, 1);
    chk("R9 zero err", err, 1);
    run_job(32'd1, 32'd100, lat);
    chk("R9 tiny src err", err, 1);
    chk("R9 tiny src latency", lat, 1);
    // R10 pulse width and hold
    job_vs_model("R10 job", 32'd52_000_000, 32'd400_000);
    e0 = err; s0 = sample_enc; t0 = step_enc;
    @(negedge clk);
    chk("R10 done low", done, 0);
    repeat (5) @(negedge clk);
    chk("R10 hold sample", sample_enc, s0);
    chk("R10 hold step", step_enc, t0);
    chk("R10 hold err", err, e0);
    // R11 start while busy ignored
    @(negedge clk);
    src_hz = 32'd100_000_000; target_hz = 32'd100_000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    src_hz = 32'd13_000_000; target_hz = 32'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R11 no early done", done, 0);
    lat = 0;
    while (!done && lat < 5000) begin @(negedge clk); lat++; end
    model(100_000_000, 100_000, e, se, te);
    chk("R11 err", err, e);
    chk("R11 sample_enc", sample_enc, se);
    chk("R11 step_enc", step_enc, te);
    // random mix (R4 R5 R7 R8)
    for (int i = 0; i < 120; i++) begin
      logic [31:0] rs, rt;
      rs = 32'd1_000_000 + ($urandom % 32'd300_000_000);
      case ($urandom % 4)
        0: rt = 32'd1 + ($urandom % 32'd100_000);
        1: rt = 32'd1 + ($urandom % 32'd400_000);
        2: rt = 32'd400_001 + ($urandom % 32'd4_000_000);
        default: rt = $urandom % 32'd5_000;
      endcase
      job_vs_model("R5 random", rs, rt);
    end
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule